// File: doc/BRIEF.md
# Four-Word Nonvolatile Store Controller

This block keeps four 9-bit retained words and serves the memory side of a serial-controlled digital potentiometer. Each word holds an output-mode bit (bit 8) and an 8-bit tap setting (bits 7..0). A command unit hands the block one request at a time: wipe a word, write a word from supplied data, write a word from the current tap setting, read a word back, or recall a word into the tap register. The words are ordinary registers whose reset values stand in for what the cells retained across power loss.

Writes model real cell behaviour. A wipe sets every bit to one, and a write can only clear bits. Writing a word that was not wiped first therefore stores the AND of the old and new values, and the block flags the mismatch. An active-low protect input blocks wipes and writes but leaves reads and recalls working. Every effective access holds a busy flag for a parameterised number of cycles. Requests that arrive while busy is high are dropped. At power-up (reset) the block presents location 0 on its recall output.

Top module: `nvs_ctrl`

## Requirements
- R1: While reset is held, `rc_vld` is 1, `rc_data` equals the initial value of location 0 and `busy` is 1. After reset is released, `busy` stays high for exactly BUSY_CYCLES cycles.
- R2: Requests are decoded on `req_op` as follows: 4'b1101 wipe, 4'b0010 write from `req_data`, 4'b0011 write from `tap_in`, 4'b1010 read, 4'b1011 recall. Any other code is ignored: it raises no busy and produces no pulse.
- R3: A read request at location `req_addr` (0..3) produces, one cycle after it is accepted, a one-cycle `rd_vld` pulse with the stored word on `rd_data` (bit 8 mode, bits 7..0 tap).
- R4: A recall request produces, one cycle after it is accepted, a one-cycle `rc_vld` pulse with the stored word on `rc_data`. The stored word is left unchanged.
- R5: A wipe sets the addressed word to 9'h1FF.
- R6: A write stores the old word ANDed with the new data. When that result differs from the new data, `prog_err` pulses for one cycle, one cycle after the request is accepted.
- R7: A write from tap uses the value on `tap_in` in the cycle the request is accepted.
- R8: While `wp_n` is 0, wipe and write requests change no word and raise no busy. Read and recall requests still work.
- R9: Each effective request holds `busy` high for exactly BUSY_CYCLES cycles, starting the cycle after it is accepted. Requests presented while `busy` is high have no effect.
- R10: The initial content of location i is INIT[9*i+8 : 9*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Request code |
| req_addr | input | 2 | Word location |
| req_data | input | 9 | Data for a write request |
| tap_in | input | 9 | Current mode bit and tap setting |
| wp_n | input | 1 | Active-low write protect |
| busy | output | 1 | Access in progress; requests are dropped |
| rd_vld | output | 1 | Read result pulse |
| rd_data | output | 9 | Read result word |
| rc_vld | output | 1 | Recall pulse to the tap register |
| rc_data | output | 9 | Recalled word |
| prog_err | output | 1 | Write onto a word that was not wiped |

## Verification
The write path is tested with three patterns. A write onto a freshly wiped word must store the data exactly and raise no error. A second write with complementary bits onto the same word must collapse it to the AND of the two values and flag an error, which separates a true AND model from an overwrite. A write from the tap input uses a value that differs from `req_data`, which shows which source is selected. Protected wipes and writes, unknown codes, and requests issued during busy are each followed by a read of the affected word and by a count of busy cycles, so that dropped requests are seen to leave both the store and the timing untouched.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [3:0] {
        OP_WIPE     = 4'b1101,
        OP_WRITE    = 4'b0010,
        OP_WRITE_TP = 4'b0011,
        OP_READ     = 4'b1010,
        OP_RECALL   = 4'b1011
    } nvs_op_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_WIPE,
        CL_WRITE,
        CL_READ,
        CL_RECALL
    } nvs_cls_e;

    typedef struct packed {
        logic     go;
        nvs_cls_e cls;
        logic     from_tap;
    } nvs_dec_t;

    function automatic nvs_cls_e classify(input logic [3:0] op);
        case (op)
            OP_WIPE:     return CL_WIPE;
            OP_WRITE:    return CL_WRITE;
            OP_WRITE_TP: return CL_WRITE;
            OP_READ:     return CL_READ;
            OP_RECALL:   return CL_RECALL;
            default:     return CL_NONE;
        endcase
    endfunction

    function automatic logic alters_store(input nvs_cls_e c);
        return (c == CL_WIPE) || (c == CL_WRITE);
    endfunction

endpackage

// File: rtl/nvs_decode.sv
module nvs_decode
    import nvs_pkg::*;
(
    input  logic       req_valid,
    input  logic [3:0] req_op,
    input  logic       busy,
    input  logic       wp_n,
    output nvs_dec_t   dec
);
    nvs_cls_e cls;

    always_comb begin
        cls          = classify(req_op);
        dec.cls      = cls;
        dec.from_tap = (req_op == OP_WRITE_TP);
        dec.go       = req_valid && !busy && (cls != CL_NONE) &&
                       (!alters_store(cls) || wp_n);
    end
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(CYC);
        end else if (start) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int NWORDS = 4,
    parameter int WBITS  = 9,
    parameter logic [NWORDS*WBITS-1:0] INIT = '0,
    localparam int AW = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic             wipe,
    input  logic [WBITS-1:0] pdata,
    output logic [WBITS-1:0] cur
);
    logic [WBITS-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= INIT[g*WBITS +: WBITS];
            end else if (wr_en && (addr == AW'(g))) begin
                words[g] <= wipe ? '1 : (words[g] & pdata);
            end
        end
    end

    assign cur = words[addr];
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int NWORDS      = 4,
    parameter int WBITS       = 9,
    parameter int BUSY_CYCLES = 16,
    parameter logic [NWORDS*WBITS-1:0] INIT = {9'h155, 9'h0F0, 9'h1FF, 9'h080},
    localparam int AW = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [WBITS-1:0] req_data,
    input  logic [WBITS-1:0] tap_in,
    input  logic             wp_n,
    output logic             busy,
    output logic             rd_vld,
    output logic [WBITS-1:0] rd_data,
    output logic             rc_vld,
    output logic [WBITS-1:0] rc_data,
    output logic             prog_err
);
    nvs_dec_t         dec;
    logic             wr_en;
    logic [WBITS-1:0] pdata;
    logic [WBITS-1:0] cur;
    logic             mismatch;

    nvs_decode u_dec (
        .req_valid (req_valid),
        .req_op    (req_op),
        .busy      (busy),
        .wp_n      (wp_n),
        .dec       (dec)
    );

    nvs_timer #(.CYC(BUSY_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (dec.go),
        .busy  (busy)
    );

    assign wr_en    = dec.go && alters_store(dec.cls);
    assign pdata    = dec.from_tap ? tap_in : req_data;
    assign mismatch = ((cur & pdata) != pdata);

    nvs_array #(.NWORDS(NWORDS), .WBITS(WBITS), .INIT(INIT)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .addr  (req_addr),
        .wr_en (wr_en),
        .wipe  (dec.cls == CL_WIPE),
        .pdata (pdata),
        .cur   (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld   <= 1'b0;
            rd_data  <= '0;
            rc_vld   <= 1'b1;
            rc_data  <= INIT[WBITS-1:0];
            prog_err <= 1'b0;
        end else begin
            rd_vld   <= dec.go && (dec.cls == CL_READ);
            rc_vld   <= dec.go && (dec.cls == CL_RECALL);
            prog_err <= dec.go && (dec.cls == CL_WRITE) && mismatch;
            if (dec.go && (dec.cls == CL_READ)) begin
                rd_data <= cur;
            end
            if (dec.go && (dec.cls == CL_RECALL)) begin
                rc_data <= cur;
            end
        end
    end
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
    import nvs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [3:0] req_op,
    input logic       wp_n,
    input logic       busy,
    input logic       rd_vld,
    input logic       rc_vld,
    input logic       prog_err
);
    logic known_op;
    logic store_op;

    assign known_op = (classify(req_op) != CL_NONE);
    assign store_op = alters_store(classify(req_op));

    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_vld && !rc_vld && !prog_err); // R9

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_vld, rc_vld, prog_err})); // R3

    AST_RESULT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (rd_vld || rc_vld || prog_err) |-> busy); // R9

    AST_PROTECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !wp_n && store_op) |=> !busy); // R8

    AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !known_op) |=> !busy); // R2

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op == OP_READ) |=> rd_vld); // R3

    AST_RECALL_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op == OP_RECALL) |=> rc_vld); // R4
endmodule

bind nvs_ctrl nvs_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .wp_n      (wp_n),
    .busy      (busy),
    .rd_vld    (rd_vld),
    .rc_vld    (rc_vld),
    .prog_err  (prog_err)
);

// File: tb/sim_nvs_ctrl.sv
module sim_nvs_ctrl;
    localparam int BUSY = 5;
    localparam logic [35:0] INIT = {9'h155, 9'h0F0, 9'h1FF, 9'h080};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = 4'h0;
    logic [1:0] req_addr = 2'd0;
    logic [8:0] req_data = 9'h0;
    logic [8:0] tap_in = 9'h0;
    logic       wp_n = 1'b1;
    logic       busy, rd_vld, rc_vld, prog_err;
    logic [8:0] rd_data, rc_data;

    always #4 clk = ~clk;

    nvs_ctrl #(.BUSY_CYCLES(BUSY), .INIT(INIT)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .tap_in(tap_in), .wp_n(wp_n),
        .busy(busy), .rd_vld(rd_vld), .rd_data(rd_data), .rc_vld(rc_vld),
        .rc_data(rc_data), .prog_err(prog_err)
    );

    typedef struct packed {
        logic [1:0] kind;   // 1 read, 2 recall, 3 write error
        logic [8:0] data;
        logic [3:0] rq;     // requirement number for messages
    } exp_t;

    exp_t       q[$];
    int         total = 0;
    int         bad = 0;
    logic       mon_on = 1'b0;
    logic       done = 1'b0;
    logic [8:0] m [4];

    task automatic check(input logic ok, input string rq, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // monitor: pop expected results as the design produces them
    always @(negedge clk) begin
        if (mon_on && (rd_vld || rc_vld || prog_err)) begin
            logic [1:0] k;
            logic [8:0] d;
            k = rd_vld ? 2'd1 : (rc_vld ? 2'd2 : 2'd3);
            d = rd_vld ? rd_data : (rc_vld ? rc_data : 9'h0);
            if (q.size() == 0) begin
                check(1'b0, "R9 unexpected result", {k, d}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({k, d} == {e.kind, e.data}, $sformatf("R%0d result", e.rq),
                      {k, d}, {e.kind, e.data});
            end
        end
    end

    // driver: waits for idle, issues one request, pushes expected items, times busy
    task automatic do_cmd(input logic [3:0] op, input logic [1:0] a,
                          input logic [8:0] d, input logic [3:0] rq);
        logic eff;
        logic store;
        logic [8:0] src;
        int   n;
        while (busy) @(negedge clk);
        store = (op == 4'b1101) || (op == 4'b0010) || (op == 4'b0011);
        eff   = (store && wp_n) || (op == 4'b1010) || (op == 4'b1011);
        src   = (op == 4'b0011) ? tap_in : d;
        if (eff) begin
            case (op)
                4'b1101: m[a] = 9'h1FF;
                4'b1010: q.push_back('{kind: 2'd1, data: m[a], rq: rq});
                4'b1011: q.push_back('{kind: 2'd2, data: m[a], rq: rq});
                default: begin
                    if ((m[a] & src) != src)
                        q.push_back('{kind: 2'd3, data: 9'h0, rq: 4'd6});
                    m[a] = m[a] & src;
                end
            endcase
        end
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check(n == (eff ? BUSY : 0), $sformatf("R%0d busy length", eff ? 9 : rq), n,
              eff ? BUSY : 0);
    endtask

    initial begin
        int n;
        for (int i = 0; i < 4; i++) m[i] = INIT[i*9 +: 9];
        repeat (3) @(negedge clk);
        // R1 power-up state with location 0 recalled
        check(rc_vld == 1'b1, "R1 rc_vld in reset", rc_vld, 1);
        check(rc_data == 9'h080, "R1 rc_data in reset", rc_data, 9'h080);
        check(busy == 1'b1, "R1 busy in reset", busy, 1);
        check(rd_vld == 1'b0 && prog_err == 1'b0, "R1 idle pulses in reset",
              {rd_vld, prog_err}, 0);
        rst = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
            mon_on = 1'b1;
        end
        check(n == BUSY, "R1 busy after release", n, BUSY);

        // R3 R10 read every location
        for (int i = 0; i < 4; i++) do_cmd(4'b1010, 2'(i), 9'h0, 4'd10);
        // R4 recall, word unchanged
        do_cmd(4'b1011, 2'd3, 9'h0, 4'd4);
        do_cmd(4'b1010, 2'd3, 9'h0, 4'd4);
        // R5 wipe
        do_cmd(4'b1101, 2'd2, 9'h0, 4'd5);
        do_cmd(4'b1010, 2'd2, 9'h0, 4'd5);
        // R6 write onto wiped word, then complementary write onto unwiped word
        do_cmd(4'b0010, 2'd2, 9'h0A5, 4'd6);
        do_cmd(4'b1010, 2'd2, 9'h0, 4'd6);
        do_cmd(4'b0010, 2'd2, 9'h15A, 4'd6);
        do_cmd(4'b1010, 2'd2, 9'h0, 4'd6);
        // R7 write from tap, req_data differs
        tap_in = 9'h13C;
        do_cmd(4'b1101, 2'd1, 9'h0, 4'd7);
        do_cmd(4'b0011, 2'd1, 9'h0C3, 4'd7);
        tap_in = 9'h000;
        do_cmd(4'b1010, 2'd1, 9'h0, 4'd7);
        // R8 protect blocks wipe and writes, read and recall still work
        wp_n = 1'b0;
        do_cmd(4'b1101, 2'd0, 9'h0, 4'd8);
        do_cmd(4'b0010, 2'd3, 9'h000, 4'd8);
        do_cmd(4'b0011, 2'd3, 9'h000, 4'd8);
        do_cmd(4'b1010, 2'd0, 9'h0, 4'd8);
        do_cmd(4'b1011, 2'd3, 9'h0, 4'd8);
        wp_n = 1'b1;
        // R2 unknown codes ignored
        do_cmd(4'b0000, 2'd0, 9'h0, 4'd2);
        do_cmd(4'b1100, 2'd0, 9'h0, 4'd2);
        do_cmd(4'b1111, 2'd1, 9'h0, 4'd2);
        // R9 requests during busy are dropped
        q.push_back('{kind: 2'd1, data: m[3], rq: 4'd9});
        req_valid = 1'b1; req_op = 4'b1010; req_addr = 2'd3;
        @(negedge clk);
        req_op = 4'b1101; req_addr = 2'd0;
        @(negedge clk);
        req_op = 4'b1011;
        @(negedge clk);
        req_valid = 1'b0;
        do_cmd(4'b1010, 2'd0, 9'h0, 4'd9);
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R9 all expected results seen", q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule